// File: doc/BRIEF.md
# Accumulator Execute Stage with Immediate Operations

This block is the execute stage of an accumulator machine. Each cycle in which `in_valid` is high it takes a 6-bit opcode, a 32-bit operand (already fetched from memory or taken as an immediate) and the current accumulator. One clock later it presents the new accumulator value together with a write strobe. For increment and decrement it also presents a write-back value, so the surrounding pipeline can store the updated variable.

The opcode space is fixed. Register-operand binary operations and their immediate counterparts share one datapath, and the operand is always the right-hand side: result = acc op operand. Only some operations have an immediate form. An opcode that this stage does not execute is flagged as rejected and writes nothing. Memory access, branching and the stack are outside this block.

Top module: `alu_exec_stage`

## Requirements
- R1: Opcodes 1 add, 2 sub, 3 mul (low 32 bits of the product), 5 and, 6 or and 7 xor compute acc op operand and raise `acc_we`.
- R2: Opcodes 4 div and 8 mod are signed and truncate toward zero, so the remainder takes the sign of the dividend. The case -2^31 / -1 gives -2^31 for div and 0 for mod.
- R3: A div or mod with an operand of 0 gives a result of 0 with `acc_we` high, and raises `div_zero` for exactly that one result cycle.
- R4: Comparisons compare acc against the operand as signed numbers and give 1 when true and 0 when false. The opcodes are 9 eq, 10 ne, 11 lt, 12 le, 13 gt and 14 ge.
- R5: Opcodes 15 shl and 16 shr shift acc by the low 5 bits of the operand. shr is logical and fills with zeros.
- R6: The immediate opcodes are 17 add, 18 sub, 19 and, 20 or, 21 eq, 22 lt, 23 le, 24 shl and 25 shr. Each behaves exactly like its register-operand form.
- R7: Opcode 28 loads the operand into acc unchanged. Opcode 30 gives 1 when acc is 0 and 0 otherwise.
- R8: Opcodes 26 and 27 give operand+1 and operand-1 (wrapping modulo 2^32). The value appears on `acc_result` and on `wb_data`, with both `acc_we` and `wb_we` high.
- R9: Any other opcode (0, 29 and 31 to 63) raises `op_reject`. It leaves `acc_we`, `wb_we` and `div_zero` low and drives `acc_result` to 0.
- R10: The results of an input accepted at one rising edge appear after that edge with `out_valid` high. A cycle with `in_valid` low yields `out_valid` low and every strobe low.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode, operand and acc are valid this cycle |
| opcode | input | 6 | Operation code |
| operand | input | 32 | Memory value or immediate |
| acc | input | 32 | Current accumulator |
| out_valid | output | 1 | Result registers hold a new result |
| acc_we | output | 1 | Write `acc_result` into the accumulator |
| acc_result | output | 32 | New accumulator value |
| wb_we | output | 1 | Store `wb_data` back to the variable |
| wb_data | output | 32 | Incremented or decremented variable |
| div_zero | output | 1 | Division or modulo by zero occurred |
| op_reject | output | 1 | Opcode is not executed by this stage |

## Verification
The hardest cases to reach from the ports sit at the edges of the signed division and the opcode space. These are the quotient that overflows (-2^31 / -1), zero divisors, remainders with a negative dividend, and opcodes that lie in the gaps between the executed ones. The stimulus aims at them directly with crafted operand and acc pairs. It also sends every opcode from 0 to 63 once, so each missing immediate form and unused code is shown to be rejected. Shift amounts of 0, 31, 32 and 33 show that only the low 5 bits count. Results are issued back to back and also with idle gaps, to exercise the one-cycle timing and the quiet idle cycles.

// File: rtl/alu_imm_pkg.sv
package alu_imm_pkg;

    localparam int XLEN  = 32;
    localparam int OPC_W = 6;

    typedef enum logic [4:0] {
        FN_NONE, FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_MOD,
        FN_AND, FN_OR, FN_XOR,
        FN_EQ, FN_NE, FN_LT, FN_LE, FN_GT, FN_GE,
        FN_SHL, FN_SHR, FN_LIT, FN_NOT, FN_INC, FN_DEC
    } alu_fn_e;

    typedef enum logic [1:0] {
        UNIT_ARITH, UNIT_DIV, UNIT_CMP
    } alu_unit_e;

    typedef struct packed {
        alu_fn_e   fn;
        alu_unit_e unit;
        logic      wb;
        logic      reject;
    } dec_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_imm_pkg::*;
#(
    parameter int OPC_W_P = OPC_W
) (
    input  logic [OPC_W_P-1:0] opcode,
    output dec_t               dec
);
    alu_fn_e fn;

    always_comb begin
        unique case (int'(opcode))
            1, 17:   fn = FN_ADD;
            2, 18:   fn = FN_SUB;
            3:       fn = FN_MUL;
            4:       fn = FN_DIV;
            5, 19:   fn = FN_AND;
            6, 20:   fn = FN_OR;
            7:       fn = FN_XOR;
            8:       fn = FN_MOD;
            9, 21:   fn = FN_EQ;
            10:      fn = FN_NE;
            11, 22:  fn = FN_LT;
            12, 23:  fn = FN_LE;
            13:      fn = FN_GT;
            14:      fn = FN_GE;
            15, 24:  fn = FN_SHL;
            16, 25:  fn = FN_SHR;
            26:      fn = FN_INC;
            27:      fn = FN_DEC;
            28:      fn = FN_LIT;
            30:      fn = FN_NOT;
            default: fn = FN_NONE;
        endcase
    end

    always_comb begin
        dec.fn     = fn;
        dec.reject = (fn == FN_NONE);
        dec.wb     = (fn == FN_INC) || (fn == FN_DEC);
        case (fn)
            FN_DIV, FN_MOD:                             dec.unit = UNIT_DIV;
            FN_EQ, FN_NE, FN_LT, FN_LE, FN_GT, FN_GE:   dec.unit = UNIT_CMP;
            default:                                    dec.unit = UNIT_ARITH;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_imm_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]     shamt;
    logic [2*DATA_W-1:0] prod;

    assign shamt = rhs[SH_W-1:0];
    assign prod  = lhs * rhs;

    always_comb begin
        case (fn)
            FN_ADD:  res = lhs + rhs;
            FN_SUB:  res = lhs - rhs;
            FN_MUL:  res = prod[DATA_W-1:0];
            FN_AND:  res = lhs & rhs;
            FN_OR:   res = lhs | rhs;
            FN_XOR:  res = lhs ^ rhs;
            FN_SHL:  res = lhs << shamt;
            FN_SHR:  res = lhs >> shamt;
            FN_LIT:  res = rhs;
            FN_NOT:  res = (lhs == '0) ? DATA_W'(1) : '0;
            FN_INC:  res = rhs + DATA_W'(1);
            FN_DEC:  res = rhs - DATA_W'(1);
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_div_unit.sv
module alu_div_unit
    import alu_imm_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              want_rem,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] res,
    output logic              by_zero
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] sq, sr;
    logic                     ovf;

    assign by_zero = (divisor == '0);
    assign ovf     = (dividend == MOST_NEG) && (divisor == '1);

    always_comb begin
        if (by_zero || ovf) begin
            sq = '0;
            sr = '0;
        end else begin
            sq = $signed(dividend) / $signed(divisor);
            sr = $signed(dividend) % $signed(divisor);
        end
    end

    always_comb begin
        if (by_zero)       res = '0;
        else if (ovf)      res = want_rem ? '0 : MOST_NEG;
        else if (want_rem) res = sr;
        else               res = sq;
    end
endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import alu_imm_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);
    logic eq, lt, truth;

    assign eq = (lhs == rhs);
    assign lt = ($signed(lhs) < $signed(rhs));

    always_comb begin
        case (fn)
            FN_EQ:   truth = eq;
            FN_NE:   truth = !eq;
            FN_LT:   truth = lt;
            FN_LE:   truth = lt || eq;
            FN_GT:   truth = !(lt || eq);
            FN_GE:   truth = !lt;
            default: truth = 1'b0;
        endcase
        res = {{(DATA_W-1){1'b0}}, truth};
    end
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
    import alu_imm_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int OP_W   = OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc,
    output logic              out_valid,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_result,
    output logic              wb_we,
    output logic [DATA_W-1:0] wb_data,
    output logic              div_zero,
    output logic              op_reject
);
    typedef struct packed {
        logic              vld;
        logic              we;
        logic [DATA_W-1:0] res;
        logic              wbe;
        logic [DATA_W-1:0] wbd;
        logic              dz;
        logic              rej;
    } stage_t;

    dec_t              dec;
    logic [DATA_W-1:0] arith_res, div_res, cmp_res, sel_res;
    logic              dz_raw;
    stage_t            st_d, st_q;

    alu_op_decode #(.OPC_W_P(OP_W)) u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .fn  (dec.fn),
        .lhs (acc),
        .rhs (operand),
        .res (arith_res)
    );

    alu_div_unit #(.DATA_W(DATA_W)) u_div (
        .want_rem (dec.fn == FN_MOD),
        .dividend (acc),
        .divisor  (operand),
        .res      (div_res),
        .by_zero  (dz_raw)
    );

    alu_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
        .fn  (dec.fn),
        .lhs (acc),
        .rhs (operand),
        .res (cmp_res)
    );

    always_comb begin
        case (dec.unit)
            UNIT_DIV: sel_res = div_res;
            UNIT_CMP: sel_res = cmp_res;
            default:  sel_res = arith_res;
        endcase
    end

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            st_d.rej = dec.reject;
            if (!dec.reject) begin
                st_d.we  = 1'b1;
                st_d.res = sel_res;
                st_d.dz  = (dec.unit == UNIT_DIV) && dz_raw;
                st_d.wbe = dec.wb;
                st_d.wbd = dec.wb ? sel_res : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign acc_we     = st_q.we;
    assign acc_result = st_q.res;
    assign wb_we      = st_q.wbe;
    assign wb_data    = st_q.wbd;
    assign div_zero   = st_q.dz;
    assign op_reject  = st_q.rej;
endmodule

// File: rtl/alu_exec_stage_chk.sv
module alu_exec_stage_chk #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   opcode,
    input logic [DATA_W-1:0] operand,
    input logic              out_valid,
    input logic              acc_we,
    input logic [DATA_W-1:0] acc_result,
    input logic              wb_we,
    input logic [DATA_W-1:0] wb_data,
    input logic              div_zero,
    input logic              op_reject
);
    logic is_cmp_op;
    assign is_cmp_op = (int'(opcode) >= 9 && int'(opcode) <= 14) ||
                       (int'(opcode) >= 21 && int'(opcode) <= 23);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !acc_we && !wb_we && !div_zero && !op_reject)); // R10
    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        op_reject |-> (!acc_we && !wb_we && !div_zero && acc_result == '0)); // R9
    AST_DZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (acc_we && acc_result == '0)); // R3
    AST_DZ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && operand == '0 && (int'(opcode) == 4 || int'(opcode) == 8)) |=> div_zero); // R3
    AST_WB_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (acc_we && wb_data == acc_result)); // R8
    AST_INC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(opcode) == 26) |=> (acc_result == $past(operand) + DATA_W'(1))); // R8
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp_op) |=> (acc_result[DATA_W-1:1] == '0)); // R4
    AST_LIT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(opcode) == 28) |=> (acc_result == $past(operand))); // R7
endmodule

bind alu_exec_stage alu_exec_stage_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .operand    (operand),
    .out_valid  (out_valid),
    .acc_we     (acc_we),
    .acc_result (acc_result),
    .wb_we      (wb_we),
    .wb_data    (wb_data),
    .div_zero   (div_zero),
    .op_reject  (op_reject)
);

// File: tb/alu_exec_stage_test.sv
module alu_exec_stage_test;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [5:0]    opcode = '0;
    logic [W-1:0]  operand = '0;
    logic [W-1:0]  acc = '0;
    logic          out_valid, acc_we, wb_we, div_zero, op_reject;
    logic [W-1:0]  acc_result, wb_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         we;
        logic         wbe;
        logic         dz;
        logic         rej;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    alu_exec_stage uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .acc(acc), .out_valid(out_valid), .acc_we(acc_we),
        .acc_result(acc_result), .wb_we(wb_we), .wb_data(wb_data),
        .div_zero(div_zero), .op_reject(op_reject)
    );

    function automatic exp_t model(int op, logic [W-1:0] a, logic [W-1:0] b, string tag);
        exp_t e;
        logic signed [W-1:0] sa, sb_;
        sa = a; sb_ = b;
        e.res = '0; e.we = 1'b1; e.wbe = 1'b0; e.dz = 1'b0; e.rej = 1'b0; e.tag = tag;
        case (op)
            1, 17:  e.res = a + b;
            2, 18:  e.res = a - b;
            3:      e.res = a * b;
            5, 19:  e.res = a & b;
            6, 20:  e.res = a | b;
            7:      e.res = a ^ b;
            4, 8: begin
                if (b == 0) begin e.res = 0; e.dz = 1'b1; end
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) e.res = (op == 4) ? a : 0;
                else e.res = (op == 4) ? W'(sa / sb_) : W'(sa % sb_);
            end
            9, 21:  e.res = (a == b) ? 1 : 0;
            10:     e.res = (a != b) ? 1 : 0;
            11, 22: e.res = (sa < sb_) ? 1 : 0;
            12, 23: e.res = (sa <= sb_) ? 1 : 0;
            13:     e.res = (sa > sb_) ? 1 : 0;
            14:     e.res = (sa >= sb_) ? 1 : 0;
            15, 24: e.res = a << b[4:0];
            16, 25: e.res = a >> b[4:0];
            26: begin e.res = b + 1; e.wbe = 1'b1; end
            27: begin e.res = b - 1; e.wbe = 1'b1; end
            28:     e.res = b;
            30:     e.res = (a == 0) ? 1 : 0;
            default: begin e.we = 1'b0; e.rej = 1'b1; end
        endcase
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(int op, logic [W-1:0] a, logic [W-1:0] b, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = 6'(op);
        acc      = a;
        operand  = b;
        sb.push_back(model(op, a, b, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode   = 6'h3F;
            operand  = '0;
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected out_valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(acc_result == e.res, e.tag, "acc_result", acc_result, e.res);
                    check(acc_we == e.we, e.tag, "acc_we", W'(acc_we), W'(e.we));
                    check(wb_we == e.wbe, e.tag, "wb_we", W'(wb_we), W'(e.wbe));
                    if (e.wbe)
                        check(wb_data == e.res, e.tag, "wb_data", wb_data, e.res);
                    check(div_zero == e.dz, e.tag, "div_zero", W'(div_zero), W'(e.dz));
                    check(op_reject == e.rej, e.tag, "op_reject", W'(op_reject), W'(e.rej));
                end
            end else begin
                check(!acc_we && !wb_we && !div_zero && !op_reject, "R10", "strobes while idle",
                      W'({acc_we, wb_we, div_zero, op_reject}), 0);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset state, with stimulus on the inputs
        in_valid = 1'b1; opcode = 6'd1; operand = 32'h5; acc = 32'h7;
        repeat (3) @(posedge clk);
        #1;
        check({out_valid, acc_we, wb_we, div_zero, op_reject} == 0 && acc_result == 0 && wb_data == 0,
              "R11", "outputs in reset", acc_result | wb_data | W'({out_valid, acc_we, wb_we, div_zero, op_reject}), 0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R1 basic binary ops
        issue(1, 32'hFFFF_FFFF, 32'h2, "R1");
        issue(2, 32'h5, 32'h9, "R1");
        issue(3, 32'h1234_5678, 32'h9ABC_DEF0, "R1");
        issue(3, 32'hFFFF_FFFD, 32'h7, "R1");
        issue(5, 32'hF0F0_1234, 32'h0FF0_FFFF, "R1");
        issue(6, 32'hF000_0001, 32'h0000_0F10, "R1");
        issue(7, 32'hAAAA_5555, 32'hFFFF_0000, "R1");
        idle(1);
        // R2 signed division and modulo
        issue(4, 32'd100, 32'd7, "R2");
        issue(4, -32'sd100, 32'd7, "R2");
        issue(8, -32'sd100, 32'd7, "R2");
        issue(8, 32'd100, -32'sd7, "R2");
        issue(4, 32'h8000_0000, 32'hFFFF_FFFF, "R2");
        issue(8, 32'h8000_0000, 32'hFFFF_FFFF, "R2");
        // R3 divide by zero, then a normal result right after
        issue(4, 32'd55, 32'd0, "R3");
        issue(4, 32'd55, 32'd5, "R3");
        issue(8, 32'h8000_0000, 32'd0, "R3");
        idle(2);
        // R4 signed compares
        issue(9, 32'd3, 32'd3, "R4");
        issue(10, 32'd3, 32'd3, "R4");
        issue(11, 32'hFFFF_FFFF, 32'd1, "R4");
        issue(12, 32'd1, 32'hFFFF_FFFF, "R4");
        issue(13, 32'd1, 32'hFFFF_FFFF, "R4");
        issue(14, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        issue(12, 32'd4, 32'd4, "R4");
        // R5 shifts, amount taken modulo 32, logical right
        issue(15, 32'h0000_0003, 32'd33, "R5");
        issue(15, 32'h0000_0001, 32'd31, "R5");
        issue(16, 32'h8000_0000, 32'd31, "R5");
        issue(16, 32'hF000_0000, 32'd4, "R5");
        issue(16, 32'hDEAD_BEEF, 32'd32, "R5");
        // R6 immediate forms
        issue(17, 32'd10, 32'd20, "R6");
        issue(18, 32'd10, 32'd20, "R6");
        issue(19, 32'hFF00_FF00, 32'h0FF0_0FF0, "R6");
        issue(20, 32'h1, 32'h80, "R6");
        issue(21, 32'd9, 32'd8, "R6");
        issue(22, 32'hFFFF_FFF0, 32'd0, "R6");
        issue(23, 32'd0, 32'd0, "R6");
        issue(24, 32'd1, 32'd36, "R6");
        issue(25, 32'h8000_0000, 32'd1, "R6");
        // R7 lit and not
        issue(28, 32'h1111_1111, 32'hCAFE_F00D, "R7");
        issue(30, 32'd0, 32'd77, "R7");
        issue(30, 32'h8000_0000, 32'd0, "R7");
        // R8 inc and dec with wraparound
        issue(26, 32'd0, 32'd41, "R8");
        issue(26, 32'd0, 32'hFFFF_FFFF, "R8");
        issue(27, 32'd0, 32'd0, "R8");
        issue(27, 32'd5, 32'd100, "R8");
        idle(3);
        // R9 every opcode once: gaps and missing immediate forms rejected
        for (int op = 0; op < 64; op++) begin
            string t;
            t = (op == 0 || op == 29 || op > 30) ? "R9" : "R10";
            issue(op, 32'h0000_0F0F + W'(op), 32'd3 + W'(op), t);
        end
        idle(4);
        @(negedge clk);
        check(sb.size() == 0, "R10", "results outstanding", W'(sb.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule